// File: doc/BRIEF.md
# Return Path and Bus Arbiter

This block sits in a bus bridge and owns the bridge's transmit side of a processor bus that has exactly two masters: the bridge and the CPU. The bridge sends two kinds of item to the CPU. The first is read-return data that comes back from the system side. The second is an invalidate address, which is the address of a command that another processor started on the system bus. The two sources are queued in separate four-entry FIFOs. Both FIFOs feed one output path.

Arbitration overlaps the transfer in flight. In every cycle the block looks at what is pending and at the CPU request. From these it decides who owns the bus in the following cycle and registers that decision, so the request-to-grant loop closes in one bus cycle. The bridge always wins over the CPU. A read return is four 64-bit beats that go out back to back with no regrant between them. A read return beats a waiting invalidate, unless that invalidate has been waiting long enough. When nothing is pending and the CPU does not request, the grant parks on the CPU.

Top module: `bridge_return_arb`

## Requirements
- R1: If either FIFO holds an item in cycle t, the bridge owns the bus in cycle t+1. In that cycle `cpu_gnt` is 0 whatever `cpu_req` is.
- R2: Ownership is decided from the state and inputs of cycle t and shows on the outputs in cycle t+1. With no bridge item pending, `cpu_req`=1 in cycle t gives `bus_owner`=2'b01 in cycle t+1.
- R3: If no item is pending, no burst is open and `cpu_req`=0, the next cycle shows `bus_owner`=2'b00 (parked) and `cpu_gnt`=1.
- R4: A read entry is sent as four consecutive beats with `brg_drive`=1 and `brg_is_inv`=0. The beats go out least-significant 64 bits first, and `brg_last`=1 on the fourth beat only. No arbitration takes place between the beats.
- R5: An invalidate goes out as one beat with `brg_is_inv`=1 and `brg_last`=1. The address sits in bits 31:0 of `brg_data` and the upper bits are zero.
- R6: At a decision point where both FIFOs hold items and the oldest invalidate's age is below 8, the read goes first.
- R7: The age of the head invalidate is 0 in the cycle after it becomes head. It rises by one each cycle and saturates at 8. At a decision point, an age of 8 sends that invalidate before any queued read.
- R8: Each FIFO holds 4 entries. Its ready output is 0 exactly when it is full. A valid item offered while ready is 0 is dropped and never appears on the bus.
- R9: After reset: `bus_owner`=2'b00, `cpu_gnt`=1, `brg_drive`=0, `brg_data`=0, and both ready outputs are 1.
- R10: Within each source, items leave in the order they were accepted. `bus_owner` is 2'b10 exactly in the cycles where `brg_drive`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read-return entry offered |
| rd_ready | output | 1 | Read-return FIFO not full |
| rd_entry | input | 256 | Four 64-bit beats, beat 0 in bits 63:0 |
| inv_valid | input | 1 | Invalidate address offered |
| inv_ready | output | 1 | Invalidate FIFO not full |
| inv_addr | input | 32 | Address seen on the system bus |
| cpu_req | input | 1 | CPU requests the bus for the next cycle |
| cpu_gnt | output | 1 | CPU owns the bus this cycle |
| bus_owner | output | 2 | 00 parked on CPU, 01 CPU on request, 10 bridge |
| brg_drive | output | 1 | Bridge drives the bus this cycle |
| brg_is_inv | output | 1 | Current beat is an invalidate address |
| brg_last | output | 1 | Final beat of the current item |
| brg_data | output | 64 | Beat driven by the bridge |

## Verification
On every cycle, the embedded properties check the following:
- The bridge takes the bus when an item is pending.
- The grant parks on the CPU when nothing is pending and the CPU is not requesting.
- A read burst keeps the bus until its last beat.
- The ordering between reads and invalidates follows the age threshold.
- A FIFO is never pushed when full or popped when empty.

Some behaviour only the bench's cycle-accurate model can show. This covers the exact beat contents and their order, FIFO ordering across several entries, and the dropping of items offered while a FIFO is full. It also covers the moment an aged invalidate cuts in behind an open burst, and the parked-versus-requested owner code.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        OWN_PARK = 2'b00,
        OWN_CPU  = 2'b01,
        OWN_BRG  = 2'b10
    } owner_e;

endpackage

// File: rtl/brt_fifo.sv
module brt_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t q, d;

    always_comb begin
        d = q;
        if (push) begin
            d.mem[q.wp] = push_data;
            d.wp = (q.wp == PTR_W'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (pop) begin
            d.rp = (q.rp == PTR_W'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign full  = (q.cnt == CNT_W'(DEPTH));
    assign empty = (q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R10

endmodule

// File: rtl/brt_arb.sv
module brt_arb
    import brt_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 32,
    parameter int BEATS     = 4,
    parameter int AGE_LIMIT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_avail,
    input  logic [BEATS*DATA_W-1:0] rd_head,
    input  logic                    inv_avail,
    input  logic [ADDR_W-1:0]       inv_head,
    input  logic                    cpu_req,
    output logic                    rd_pop,
    output logic                    inv_pop,
    output logic                    cpu_gnt,
    output logic [1:0]              bus_owner,
    output logic                    brg_drive,
    output logic                    brg_is_inv,
    output logic                    brg_last,
    output logic [DATA_W-1:0]       brg_data
);
    localparam int ENT_W = BEATS * DATA_W;
    localparam int REM_W = $clog2(BEATS + 1);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1);

    typedef struct packed {
        owner_e             owner;
        logic               drive;
        logic               is_inv;
        logic               last;
        logic [DATA_W-1:0]  data;
        logic [ENT_W-1:0]   burst;
        logic [REM_W-1:0]   rem;
        logic [AGE_W-1:0]   age;
    } arb_st_t;

    arb_st_t q, d;
    logic    aged;

    always_comb begin
        d       = q;
        rd_pop  = 1'b0;
        inv_pop = 1'b0;
        aged    = inv_avail && (q.age >= AGE_W'(AGE_LIMIT));

        if (q.rem != '0) begin
            // open burst: next beat, no arbitration
            d.owner  = OWN_BRG;
            d.drive  = 1'b1;
            d.is_inv = 1'b0;
            d.data   = q.burst[DATA_W-1:0];
            d.burst  = q.burst >> DATA_W;
            d.rem    = q.rem - 1'b1;
            d.last   = (q.rem == REM_W'(1));
        end else if (inv_avail && (aged || !rd_avail)) begin
            d.owner  = OWN_BRG;
            d.drive  = 1'b1;
            d.is_inv = 1'b1;
            d.last   = 1'b1;
            d.data   = '0;
            d.data[ADDR_W-1:0] = inv_head;
            inv_pop  = 1'b1;
        end else if (rd_avail) begin
            d.owner  = OWN_BRG;
            d.drive  = 1'b1;
            d.is_inv = 1'b0;
            d.data   = rd_head[DATA_W-1:0];
            d.burst  = rd_head >> DATA_W;
            d.rem    = REM_W'(BEATS - 1);
            d.last   = (BEATS == 1);
            rd_pop   = 1'b1;
        end else begin
            d.owner  = cpu_req ? OWN_CPU : OWN_PARK;
            d.drive  = 1'b0;
            d.is_inv = 1'b0;
            d.last   = 1'b0;
            d.data   = '0;
        end

        if (!inv_avail || inv_pop)          d.age = '0;
        else if (q.age < AGE_W'(AGE_LIMIT)) d.age = q.age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.owner <= OWN_PARK;
        end else begin
            q <= d;
        end
    end

    assign cpu_gnt    = (q.owner != OWN_BRG);
    assign bus_owner  = q.owner;
    assign brg_drive  = q.drive;
    assign brg_is_inv = q.is_inv;
    assign brg_last   = q.last;
    assign brg_data   = q.data;

    AST_BRIDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_avail || inv_avail) |=> (!cpu_gnt && brg_drive)); // R1
    AST_PARK_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_avail && !inv_avail && q.rem == '0 && !cpu_req) |=> (cpu_gnt && bus_owner == 2'b00)); // R3
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brg_drive && !brg_is_inv && !brg_last) |=> (brg_drive && !brg_is_inv)); // R4
    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rem == '0 && rd_avail && inv_avail && q.age < AGE_W'(AGE_LIMIT)) |=> (brg_drive && !brg_is_inv)); // R6
    AST_AGED_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rem == '0 && aged) |=> (brg_drive && brg_is_inv)); // R7

endmodule

// File: rtl/bridge_return_arb.sv
module bridge_return_arb #(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 32,
    parameter int BEATS     = 4,
    parameter int DEPTH     = 4,
    parameter int AGE_LIMIT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_valid,
    output logic                    rd_ready,
    input  logic [BEATS*DATA_W-1:0] rd_entry,
    input  logic                    inv_valid,
    output logic                    inv_ready,
    input  logic [ADDR_W-1:0]       inv_addr,
    input  logic                    cpu_req,
    output logic                    cpu_gnt,
    output logic [1:0]              bus_owner,
    output logic                    brg_drive,
    output logic                    brg_is_inv,
    output logic                    brg_last,
    output logic [DATA_W-1:0]       brg_data
);
    localparam int ENT_W = BEATS * DATA_W;

    logic             rd_full, rd_empty, rd_pop;
    logic             inv_full, inv_empty, inv_pop;
    logic [ENT_W-1:0] rd_head;
    logic [ADDR_W-1:0] inv_head;

    assign rd_ready  = !rd_full;
    assign inv_ready = !inv_full;

    brt_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_rd_q (
        .clk(clk), .rst_n(rst_n),
        .push(rd_valid && rd_ready), .push_data(rd_entry),
        .pop(rd_pop), .head(rd_head), .full(rd_full), .empty(rd_empty)
    );

    brt_fifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_inv_q (
        .clk(clk), .rst_n(rst_n),
        .push(inv_valid && inv_ready), .push_data(inv_addr),
        .pop(inv_pop), .head(inv_head), .full(inv_full), .empty(inv_empty)
    );

    brt_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BEATS(BEATS), .AGE_LIMIT(AGE_LIMIT)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .rd_avail(!rd_empty), .rd_head(rd_head),
        .inv_avail(!inv_empty), .inv_head(inv_head),
        .cpu_req(cpu_req),
        .rd_pop(rd_pop), .inv_pop(inv_pop),
        .cpu_gnt(cpu_gnt), .bus_owner(bus_owner),
        .brg_drive(brg_drive), .brg_is_inv(brg_is_inv),
        .brg_last(brg_last), .brg_data(brg_data)
    );

    AST_OWNER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owner == 2'b10) == brg_drive); // R10

endmodule

// File: tb/sim_bridge_return_arb.sv
module sim_bridge_return_arb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_valid = 1'b0, inv_valid = 1'b0, cpu_req = 1'b0;
    logic [255:0] rd_entry = '0;
    logic [31:0]  inv_addr = '0;
    logic         rd_ready, inv_ready, cpu_gnt, brg_drive, brg_is_inv, brg_last;
    logic [1:0]   bus_owner;
    logic [63:0]  brg_data;

    int checks = 0;
    int fails  = 0;
    string tag = "R9";

    // reference model state
    logic [255:0] rq[$];
    logic [31:0]  iq[$];
    int           age = 0, rem = 0;
    logic [255:0] burst = '0;
    logic [1:0]   e_owner = 2'b00;
    logic         e_drive = 0, e_inv = 0, e_last = 0;
    logic [63:0]  e_data = '0;

    always #10 clk = ~clk;

    bridge_return_arb u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_entry(rd_entry),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr),
        .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .bus_owner(bus_owner),
        .brg_drive(brg_drive), .brg_is_inv(brg_is_inv),
        .brg_last(brg_last), .brg_data(brg_data)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [255:0] mk_rd(input int id);
        logic [255:0] v;
        for (int b = 0; b < 4; b++)
            v[b*64 +: 64] = 64'hA500_0000_0000_0000 | (64'(id) << 8) | 64'(b);
        return v;
    endfunction

    task automatic compare_all();
        chk("bus_owner", 64'(bus_owner), 64'(e_owner));
        chk("cpu_gnt",   64'(cpu_gnt),   64'(e_owner != 2'b10));
        chk("brg_drive", 64'(brg_drive), 64'(e_drive));
        chk("brg_is_inv",64'(brg_is_inv),64'(e_inv));
        chk("brg_last",  64'(brg_last),  64'(e_last));
        chk("brg_data",  brg_data,       e_data);
        chk("rd_ready",  64'(rd_ready),  64'(rq.size() < 4));
        chk("inv_ready", 64'(inv_ready), 64'(iq.size() < 4));
    endtask

    // one bus cycle: compare, drive, advance model
    task automatic step(input logic rv, input logic [255:0] rd, input logic iv,
                        input logic [31:0] ia, input logic cr);
        logic rd_rdy, inv_rdy, rd_av, inv_av, ipop;
        @(negedge clk);
        compare_all();
        rd_valid = rv; rd_entry = rd; inv_valid = iv; inv_addr = ia; cpu_req = cr;
        rd_rdy = rq.size() < 4; inv_rdy = iq.size() < 4;
        rd_av = rq.size() > 0;  inv_av = iq.size() > 0;
        ipop = 0;
        if (rem > 0) begin
            e_owner = 2'b10; e_drive = 1; e_inv = 0;
            e_data = burst[63:0]; burst = burst >> 64; rem--; e_last = (rem == 0);
        end else if (inv_av && (age >= 8 || !rd_av)) begin
            e_owner = 2'b10; e_drive = 1; e_inv = 1; e_last = 1;
            e_data = {32'h0, iq.pop_front()}; ipop = 1;
        end else if (rd_av) begin
            logic [255:0] e;
            e = rq.pop_front();
            e_owner = 2'b10; e_drive = 1; e_inv = 0; e_last = 0;
            e_data = e[63:0]; burst = e >> 64; rem = 3;
        end else begin
            e_owner = cr ? 2'b01 : 2'b00; e_drive = 0; e_inv = 0; e_last = 0; e_data = '0;
        end
        if (!inv_av || ipop) age = 0;
        else if (age < 8)    age++;
        if (rv && rd_rdy)  rq.push_back(rd);
        if (iv && inv_rdy) iq.push_back(ia);
    endtask

    task automatic idle(input int n, input logic cr);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, cr);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        tag = "R9";
        chk("reset owner", 64'(bus_owner), 64'd0);
        chk("reset cpu_gnt", 64'(cpu_gnt), 64'd1);
        chk("reset drive", 64'(brg_drive), 64'd0);
        chk("reset rd_ready", 64'(rd_ready), 64'd1);

        tag = "R2"; // requested vs parked owner codes, one-cycle loop
        step(0, '0, 0, '0, 1); step(0, '0, 0, '0, 1);
        step(0, '0, 0, '0, 0); step(0, '0, 0, '0, 1);
        tag = "R3"; idle(4, 0);

        tag = "R4"; // two reads back to back, ordered beats
        step(1, mk_rd(1), 0, '0, 1);
        step(1, mk_rd(2), 0, '0, 1);
        idle(12, 1);

        tag = "R5"; // invalidates, address in low bits
        step(0, '0, 1, 32'hDEAD_0040, 0);
        step(0, '0, 1, 32'h0000_1F80, 1);
        idle(6, 0);

        tag = "R6"; // read ahead of young invalidate
        step(1, mk_rd(3), 1, 32'h1234_5600, 1);
        idle(10, 0);

        tag = "R7"; // invalidate ages past reads
        step(1, mk_rd(4), 1, 32'h0BAD_C0C0, 1);
        for (int i = 5; i < 15; i++) step(1, mk_rd(i), 0, '0, 1);
        idle(40, 0);

        tag = "R8"; // overflow: offered while full is dropped
        for (int i = 20; i < 27; i++) step(1, mk_rd(i), 1, 32'(i * 64), 0);
        idle(60, 1);

        tag = "R10"; // ordering under mixed traffic
        for (int i = 0; i < 20; i++) step(1, mk_rd(100 + i), (i % 3) == 0, 32'(i), i[0]);
        idle(60, 0);

        tag = "R1"; // random pressure with cpu requests
        for (int i = 0; i < 400; i++)
            step(($urandom % 3) == 0, mk_rd(200 + i), ($urandom % 4) == 0,
                 $urandom, $urandom % 2 == 1);
        idle(80, 1);

        finish_run();
    end
endmodule